// File: doc/BRIEF.md
# Shared Ready/Data Output Pin Sequencer

This block drives the single digital output pin of a sigma-delta converter's result interface. The pin carries two things in turn. First comes a ready handshake: a low pulse followed by a high pulse. Then comes a serial data phase, in which the latest 24-bit result is shifted out most significant bit first, timed by a serial clock that an external host drives. The whole sequence repeats on a fixed frame of 384 system clocks.

Each frame opens with a six-clock write window. During that window the block accepts one result from the conversion source over a valid/ready stream input. `sample_ready` is high only inside the write window and only until one beat has been taken. A source that raises `sample_valid` outside the window waits, holding its data, until the next window. If no beat arrives in a window, the previous result is sent again.

The serial clock is asynchronous to the system clock, so the block synchronises it. Each falling edge of the serial clock presents the next bit, and the host samples on the following rising edge. A debug flag reports whether the current result comes from at least the sixth frame since reset. The earlier frames hold results that are not yet valid, because the filter has not settled.

Top module: `shared_pin_seq`

## Requirements
- R1: While reset is asserted, `pin_out` is 1, `result_valid_dbg` is 0 and `sample_ready` is 1. The output register is cleared to zero, and the frame restarts at the first clock of the write window.
- R2: A frame lasts FRAME_CLKS = 384 clocks. Counted from the write window, it runs as: write window for 6 clocks, low pulse for 6 clocks, high pulse for 6 clocks, data phase for 348 clocks, then a pre-write idle phase for 18 clocks, after which the next write window begins. The pin is 1 in the write and idle phases.
- R3: `sample_ready` is 1 only during the write window, and only until one beat has been accepted. A beat is taken on a clock edge where `sample_valid` and `sample_ready` are both 1, and `sample_ready` is 0 on the following cycle. A beat offered outside the window is not taken.
- R4: If no beat is accepted during a write window, the output register keeps the previous result, and that frame shifts the previous result out again.
- R5: After the write window, `pin_out` is 0 for exactly 6 clocks and then 1 for exactly 6 clocks.
- R6: On the first clock of the data phase, `pin_out` shows bit 23 (the MSB) of the output register.
- R7: Each falling edge of `sclk` in the data phase advances `pin_out` to the next lower bit. The change appears 3 system clocks after the falling edge, because `sclk` passes through a two-stage synchroniser and an edge register.
- R8: After the 24th falling edge in a frame, `pin_out` stays 1 until the end of the frame.
- R9: If fewer than 24 falling edges arrive, the unread bits are dropped. The next frame keeps its schedule and starts again from the MSB of its own result.
- R10: `sclk` edges outside the data phase have no effect on which bit is shown next.
- R11: `result_valid_dbg` is 0 for the first five frames after reset. It rises at the start of the sixth frame and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Conversion source offers a result |
| sample_ready | output | 1 | Block accepts a result this cycle (write window only) |
| sample_data | input | 24 | Conversion result |
| sclk | input | 1 | Host serial clock, asynchronous |
| pin_out | output | 1 | Shared ready/data pin |
| result_valid_dbg | output | 1 | Current result comes from the settled sixth or later frame |

## Verification
The bench builds the block with its default parameters: 24 data bits, a 384-clock frame and five unsettled frames. With these values a run of seven frames covers the whole settling count and the flag's rise in the sixth frame. It also covers a full 24-bit readout, a truncated readout, a frame with no new result, and a reset issued in the middle of a data phase. The host clock is generated at six system clocks per bit, which fits well inside the 348-clock data phase.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WRITE = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;
endpackage

// File: rtl/pinseq_frame_timer.sv
module pinseq_frame_timer
  import pinseq_pkg::*;
#(
  parameter int FRAME_CLKS = 384,
  parameter int IDLE_CLKS  = 18,
  parameter int WIN_CLKS   = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   write_entry
);
  localparam int CW   = $clog2(FRAME_CLKS);
  localparam int WR_S = IDLE_CLKS;
  localparam int LO_S = WR_S + WIN_CLKS;
  localparam int HI_S = LO_S + WIN_CLKS;
  localparam int DT_S = HI_S + WIN_CLKS;
  localparam logic [CW-1:0] WR_C   = CW'(WR_S);
  localparam logic [CW-1:0] LO_C   = CW'(LO_S);
  localparam logic [CW-1:0] HI_C   = CW'(HI_S);
  localparam logic [CW-1:0] DT_C   = CW'(DT_S);
  localparam logic [CW-1:0] LAST_C = CW'(FRAME_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= WR_C;
    else if (cnt == LAST_C) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (cnt < WR_C)      phase = PH_IDLE;
    else if (cnt < LO_C) phase = PH_WRITE;
    else if (cnt < HI_C) phase = PH_LOW;
    else if (cnt < DT_C) phase = PH_HIGH;
    else                 phase = PH_DATA;
  end

  assign write_entry = (cnt == WR_C);
endmodule

// File: rtl/pinseq_edge_sync.sv
module pinseq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/pinseq_out_shifter.sv
module pinseq_out_shifter
  import pinseq_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              fall,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  output logic              sample_ready,
  output logic              pin_out,
  output logic [$clog2(DATA_W+1)-1:0] bit_idx
);
  localparam int IW = $clog2(DATA_W + 1);
  localparam logic [IW-1:0] TOP_I = IW'(DATA_W - 1);
  localparam logic [IW-1:0] END_I = IW'(DATA_W);

  logic [DATA_W-1:0] dor;
  logic              taken;
  logic              accept;

  assign sample_ready = (phase == PH_WRITE) && !taken;
  assign accept       = sample_ready && sample_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dor     <= '0;
      taken   <= 1'b0;
      bit_idx <= '0;
    end else begin
      if (accept) dor <= sample_data;
      taken <= (phase == PH_WRITE) ? (taken | accept) : 1'b0;
      if (phase != PH_DATA)          bit_idx <= '0;
      else if (fall && bit_idx < END_I) bit_idx <= bit_idx + 1'b1;
    end
  end

  always_comb begin
    case (phase)
      PH_LOW:  pin_out = 1'b0;
      PH_DATA: pin_out = (bit_idx < END_I) ? dor[TOP_I - bit_idx] : 1'b1;
      default: pin_out = 1'b1;
    endcase
  end
endmodule

// File: rtl/pinseq_settle.sv
module pinseq_settle #(
  parameter int SETTLE_FRAMES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic write_entry,
  output logic settled
);
  localparam int SW = $clog2(SETTLE_FRAMES + 2);
  localparam logic [SW-1:0] LIM = SW'(SETTLE_FRAMES + 1);

  logic [SW-1:0] frames;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         frames <= '0;
    else if (write_entry && frames != LIM) frames <= frames + 1'b1;
  end

  assign settled = (frames == LIM);
endmodule

// File: rtl/shared_pin_seq.sv
module shared_pin_seq
  import pinseq_pkg::*;
#(
  parameter int DATA_W        = 24,
  parameter int FRAME_CLKS    = 384,
  parameter int IDLE_CLKS     = 18,
  parameter int WIN_CLKS      = 6,
  parameter int SETTLE_FRAMES = 5,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  output logic              sample_ready,
  input  logic [DATA_W-1:0] sample_data,
  input  logic              sclk,
  output logic              pin_out,
  output logic              result_valid_dbg
);
  localparam int IW = $clog2(DATA_W + 1);

  phase_e        phase;
  logic          write_entry;
  logic          fall;
  logic [IW-1:0] bit_idx;

  pinseq_frame_timer #(
    .FRAME_CLKS(FRAME_CLKS), .IDLE_CLKS(IDLE_CLKS), .WIN_CLKS(WIN_CLKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .write_entry(write_entry)
  );

  pinseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk), .fall(fall)
  );

  pinseq_out_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .phase(phase), .fall(fall),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .sample_ready(sample_ready), .pin_out(pin_out), .bit_idx(bit_idx)
  );

  pinseq_settle #(.SETTLE_FRAMES(SETTLE_FRAMES)) u_settle (
    .clk(clk), .rst_n(rst_n), .write_entry(write_entry),
    .settled(result_valid_dbg)
  );
endmodule

// File: rtl/pinseq_chk.sv
module pinseq_chk
  import pinseq_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic                        clk,
  input logic                        rst_n,
  input phase_e                      phase,
  input logic                        sample_valid,
  input logic                        sample_ready,
  input logic                        pin_out,
  input logic                        result_valid_dbg,
  input logic [$clog2(DATA_W+1)-1:0] bit_idx
);
  // R3
  ready_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ready |-> phase == PH_WRITE);

  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sample_ready) |=> !sample_ready);

  // R2
  pin_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_WRITE || phase == PH_HIGH) |-> pin_out);

  // R8
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= ($clog2(DATA_W+1))'(DATA_W));

  // R10
  no_shift_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_DATA) |=> (phase != PH_DATA) || bit_idx == '0);

  // R11
  settled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_dbg |=> result_valid_dbg);
endmodule

bind shared_pin_seq pinseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .sample_valid(sample_valid),
  .sample_ready(sample_ready), .pin_out(pin_out),
  .result_valid_dbg(result_valid_dbg), .bit_idx(bit_idx)
);

// File: tb/test_shared_pin_seq.sv
module test_shared_pin_seq;
  localparam int F = 384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic        sample_ready;
  logic [23:0] sample_data = '0;
  logic        sclk = 1'b0;
  logic        pin_out;
  logic        result_valid_dbg;

  int checks = 0;
  int failures = 0;
  int pos = 0;
  bit finished = 1'b0;

  localparam logic [23:0] WA = 24'hA5C3_96;
  localparam logic [23:0] WB = 24'h3C_0F_F1;
  localparam logic [23:0] WC = 24'hD2_6B_48;
  localparam logic [23:0] WD = 24'h1E_E1_7C;
  localparam logic [23:0] WE = 24'hB7_59_2A;

  always #5 clk = ~clk;

  shared_pin_seq i_shared_pin_seq (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .sample_ready(sample_ready), .sample_data(sample_data), .sclk(sclk),
    .pin_out(pin_out), .result_valid_dbg(result_valid_dbg)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h (pos=%0d)", req, what, act, exp, pos);
    end
  endtask

  // advance to posedge count n since reset release, sample at negedge
  task automatic goto(input int n);
    while (pos < n) begin
      @(posedge clk);
      pos++;
    end
    @(negedge clk);
  endtask

  task automatic offer(input logic [23:0] w);
    sample_data  = w;
    sample_valid = 1'b1;
  endtask

  task automatic read_bits(input string req, input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, "data bit", pin_out, w[23-i]);
      sclk = 1'b1;
      goto(pos + 2);
      sclk = 1'b0;
      goto(pos + 4);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    offer(WA);
    repeat (3) @(negedge clk);
    chk("R1", "pin in reset", pin_out, 1'b1);
    chk("R1", "valid_dbg in reset", result_valid_dbg, 1'b0);
    chk("R1", "ready in reset", sample_ready, 1'b1);
    rst_n = 1'b1;
    pos = 0;
  endtask

  task automatic t_frame_one;
    goto(1);
    chk("R3", "ready drops after beat", sample_ready, 1'b0);
    sample_valid = 1'b0;
    chk("R11", "frame1 invalid", result_valid_dbg, 1'b0);
    goto(5);
    chk("R2", "pin high in write window", pin_out, 1'b1);
    goto(6);
    chk("R5", "low start", pin_out, 1'b0);
    goto(11);
    chk("R5", "low end", pin_out, 1'b0);
    goto(12);
    chk("R5", "high pulse start", pin_out, 1'b1);
    goto(17);
    chk("R5", "high pulse end", pin_out, 1'b1);
    goto(18);
    chk("R6", "msb at data start", pin_out, WA[23]);
    read_bits("R7", WA, 24);
    chk("R8", "idle high after 24", pin_out, 1'b1);
    goto(F - 20);
    chk("R8", "still high late in data", pin_out, 1'b1);
    offer(WB);
    goto(F - 10);
    chk("R3", "no ready outside window", sample_ready, 1'b0);
  endtask

  task automatic t_truncate;
    goto(F);
    chk("R3", "ready at window start", sample_ready, 1'b1);
    goto(F + 1);
    sample_valid = 1'b0;
    goto(F + 18);
    read_bits("R7", WB, 5);
    offer(WC);
    goto(2*F - 18);
    chk("R2", "idle phase high", pin_out, 1'b1);
    // R10: sclk toggle during idle phase
    sclk = 1'b1;
    goto(pos + 2);
    sclk = 1'b0;
    goto(pos + 4);
    chk("R10", "idle sclk no effect on pin", pin_out, 1'b1);
    goto(2*F + 1);
    sample_valid = 1'b0;
    goto(2*F + 6);
    chk("R9", "low on schedule after truncation", pin_out, 1'b0);
    goto(2*F + 18);
    chk("R9", "fresh msb after truncation", pin_out, WC[23]);
    read_bits("R10", WC, 3);
  endtask

  task automatic t_hold;
    goto(3*F + 5);
    chk("R4", "ready held without beat", sample_ready, 1'b1);
    goto(3*F + 18);
    read_bits("R4", WC, 24);
    chk("R8", "idle high after repeat", pin_out, 1'b1);
  endtask

  task automatic t_settle;
    offer(WD);
    goto(4*F + 2);
    sample_valid = 1'b0;
    chk("R11", "frame5 still invalid", result_valid_dbg, 1'b0);
    offer(WE);
    goto(5*F);
    chk("R11", "frame6 not yet at window open", result_valid_dbg, 1'b0);
    goto(5*F + 2);
    sample_valid = 1'b0;
    chk("R11", "frame6 valid", result_valid_dbg, 1'b1);
    goto(5*F + 18);
    read_bits("R7", WE, 24);
    chk("R11", "valid stays", result_valid_dbg, 1'b1);
  endtask

  task automatic t_reset_mid;
    goto(pos + 3);
    rst_n = 1'b0;
    #1;
    chk("R1", "pin high on mid reset", pin_out, 1'b1);
    chk("R1", "valid cleared by reset", result_valid_dbg, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    pos = 0;
    goto(6);
    chk("R1", "frame restarts at window", pin_out, 1'b0);
    goto(18);
    chk("R1", "register cleared msb", pin_out, 1'b0);
    read_bits("R1", 24'h000000, 4);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_frame_one();
    t_truncate();
    t_hold();
    t_settle();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule